// File: doc/BRIEF.md
# Dead-Zone Voltage Loop Regulator

This block closes the outer voltage loop of a digitally controlled power-factor-correcting rectifier. On each sample strobe it takes a fine output-voltage code and a reference code and reduces their difference to a coarse signed bin index. The bin around the reference is as wide as one quantization step, and that step is set wider than the output capacitor's ripple at twice the line frequency. Steady-state ripple therefore gives an error of exactly zero, and the regulator can use a high gain without feeding the ripple into the line current.

The bin index drives an incremental proportional-integral law with fixed coefficients. The law produces an 8-bit control word that saturates at both ends. In the same sample, the updated control word is multiplied by the sampled rectified line-voltage code, and the upper half of the product becomes the current-loop reference. Samples are expected at a rate far above twice the line frequency, so a departure from the zero bin is acted on within one sample.

Top module: `dz_volt_reg`

## Requirements
- R1: A synchronous active-high `rst` clears the control word, the stored bin index and the current reference to 0.
- R2: When twice |vref_code − vout_code| is less than the step width, the bin index is 0.
- R3: With d = vref_code − vout_code and Vq the step width, the magnitude of the bin index is floor((2|d| + Vq) / (2Vq)). Its sign is the sign of d, positive when the output is below the reference. For example, with Vq = 8, d = 4 gives 1, d = 11 gives 1, d = 12 gives 2 and d = −12 gives −2.
- R4: The bin index is a 6-bit two's-complement value that saturates at +31 and −31. A step width of 0 is treated as 1.
- R5: On every valid sample, u_new = u + trunc(K·(16·e − A·e_prev) / 256). K and A are unsigned 8-bit codes with 4 fractional bits, e is the new bin index and e_prev is the bin index from the previous valid sample.
- R6: The scaled product is rounded toward zero. For example, K = 3, A = 0 and e = −1 leave u unchanged.
- R7: The control word saturates to the range 0 to 255.
- R8: The stored bin index (`err_bin`) is replaced on every valid sample, including samples where the control word is saturated. The next update uses it as e_prev.
- R9: At each valid sample, `iref` becomes bits 15:8 of u_new × vline_code.
- R10: Without `smp_vld`, all three outputs hold their values whatever the other inputs do.
- R11: All results of a valid sample appear on the outputs just after the clock edge at which `smp_vld` is high. Before that edge the outputs keep their old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Sample strobe; one regulator update per high cycle |
| vout_code | input | 8 | Sampled output-voltage code |
| vref_code | input | 8 | Reference code |
| vline_code | input | 8 | Sampled rectified line-voltage code |
| step_width | input | 8 | Coarse step width Vq in code units |
| k_gain | input | 8 | Gain K, unsigned, 4 fractional bits |
| a_coef | input | 8 | Zero coefficient A, unsigned, 4 fractional bits |
| ctl_word | output | 8 | Saturated regulator output u |
| err_bin | output | 6 | Signed bin index of the latest valid sample |
| iref | output | 8 | Current-loop reference |

## Verification
Every result of a valid sample is due one edge after it: the bench drives the inputs on a falling edge and samples all three outputs on the next falling edge. The strobe-capturing rising edge falls halfway between these two points. One scenario also looks just before that rising edge to confirm that the old values are still there. Another scenario keeps the strobe low for several cycles while the other inputs move, and checks that nothing changes. A reference model inside the bench carries its own control word and previous bin. It is advanced only on the cycles where the strobe is high, so its expected values line up with the design's single-edge latency.

// File: rtl/dzr_pkg.sv
package dzr_pkg;

   // Clip an integer to the closed range [lo, hi]
   function automatic int clip_int(input int v, input int lo, input int hi);
      if (v < lo) return lo;
      if (v > hi) return hi;
      return v;
   endfunction

   // Absolute value of an integer
   function automatic int abs_int(input int v);
      return (v < 0) ? -v : v;
   endfunction

endpackage

// File: rtl/dzr_bin_quant.sv
module dzr_bin_quant
   import dzr_pkg::*;
#(
   parameter int V_W = 8,
   parameter int E_W = 6
) (
   input  logic [V_W-1:0]        vout_code,
   input  logic [V_W-1:0]        vref_code,
   input  logic [V_W-1:0]        step_width,
   output logic signed [E_W-1:0] err
);
   localparam int E_MAX = (1 << (E_W - 1)) - 1;

   int diff_v;
   int mag_v;
   int step_v;
   int idx_v;

   always_comb begin
      diff_v = int'(vref_code) - int'(vout_code);
      mag_v  = abs_int(diff_v);
      step_v = (step_width == '0) ? 1 : int'(step_width);
      // bins are centred on the reference: 0 while 2|d| < step
      idx_v  = (2 * mag_v + step_v) / (2 * step_v);
      idx_v  = clip_int(idx_v, 0, E_MAX);
      err    = (diff_v < 0) ? E_W'(-idx_v) : E_W'(idx_v);
   end

endmodule

// File: rtl/dzr_pi_core.sv
module dzr_pi_core
   import dzr_pkg::*;
#(
   parameter int E_W  = 6,
   parameter int C_W  = 8,
   parameter int FRAC = 4,
   parameter int U_W  = 8
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  smp_vld,
   input  logic signed [E_W-1:0] err_in,
   input  logic [C_W-1:0]        k_gain,
   input  logic [C_W-1:0]        a_coef,
   output logic [U_W-1:0]        u_q,
   output logic [U_W-1:0]        u_nxt,
   output logic signed [E_W-1:0] err_q
);
   localparam int ACC_W = 2 * C_W + E_W + U_W + 2;
   localparam int U_MAX = (1 << U_W) - 1;
   localparam int E_MAX = (1 << (E_W - 1)) - 1;
   localparam logic signed [ACC_W-1:0] SCALE = ACC_W'(1) <<< (2 * FRAC);

   logic signed [ACC_W-1:0] e_x, ep_x, k_x, a_x;
   logic signed [ACC_W-1:0] t_term, prod, delta, sum;

   always_comb begin
      e_x    = ACC_W'(err_in);
      ep_x   = ACC_W'(err_q);
      k_x    = $signed({{(ACC_W - C_W){1'b0}}, k_gain});
      a_x    = $signed({{(ACC_W - C_W){1'b0}}, a_coef});
      t_term = (e_x <<< FRAC) - a_x * ep_x;
      prod   = t_term * k_x;
      delta  = prod / SCALE;           // truncates toward zero
      sum    = $signed({{(ACC_W - U_W){1'b0}}, u_q}) + delta;
      if (sum < 0)
         u_nxt = '0;
      else if (sum > ACC_W'(U_MAX))
         u_nxt = U_W'(U_MAX);
      else
         u_nxt = U_W'(sum);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         u_q   <= '0;
         err_q <= '0;
      end else if (smp_vld) begin
         u_q   <= u_nxt;
         err_q <= err_in;
      end
   end

   AST_RST_CLEAR: assert property (@(posedge clk)
      rst |=> (u_q == '0 && err_q == '0)); // R1

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      !smp_vld |=> ($stable(u_q) && $stable(err_q))); // R10

   AST_ERR_RANGE: assert property (@(posedge clk) disable iff (rst)
      smp_vld |=> (err_q <= E_W'(E_MAX) && err_q >= E_W'(-E_MAX))); // R4

   AST_ZERO_STILL: assert property (@(posedge clk) disable iff (rst)
      (smp_vld && err_in == '0 && err_q == '0) |=> $stable(u_q)); // R2

   AST_RISE_DIR: assert property (@(posedge clk) disable iff (rst)
      (smp_vld && err_q == '0 && err_in >= 0) |=> (u_q >= $past(u_q))); // R5

   AST_FALL_DIR: assert property (@(posedge clk) disable iff (rst)
      (smp_vld && err_q == '0 && err_in <= 0) |=> (u_q <= $past(u_q))); // R5

endmodule

// File: rtl/dzr_iref_mult.sv
module dzr_iref_mult #(
   parameter int U_W      = 8,
   parameter int V_W      = 8,
   parameter bit IREF_REG = 1'b1
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           smp_vld,
   input  logic [U_W-1:0] u_nxt,
   input  logic [U_W-1:0] u_q,
   input  logic [V_W-1:0] vline_code,
   output logic [U_W-1:0] iref
);
   localparam int P_W = U_W + V_W;

   logic [P_W-1:0] prod;
   logic [U_W-1:0] vline_q;

   generate
      if (IREF_REG) begin : g_reg
         assign prod = u_nxt * vline_code;
         always_ff @(posedge clk) begin
            if (rst)          iref <= '0;
            else if (smp_vld) iref <= prod[P_W-1 -: U_W];
         end
         assign vline_q = '0;
      end else begin : g_comb
         always_ff @(posedge clk) begin
            if (rst)          vline_q <= '0;
            else if (smp_vld) vline_q <= U_W'(vline_code);
         end
         assign prod = u_q * vline_q;
         assign iref = prod[P_W-1 -: U_W];
      end
   endgenerate

   AST_IREF_BOUND: assert property (@(posedge clk) disable iff (rst)
      smp_vld |=> (iref <= u_q)); // R9

   AST_IREF_HOLD: assert property (@(posedge clk) disable iff (rst)
      !smp_vld |=> $stable(iref)); // R10

endmodule

// File: rtl/dz_volt_reg.sv
module dz_volt_reg #(
   parameter int V_W      = 8,
   parameter int E_W      = 6,
   parameter int C_W      = 8,
   parameter int FRAC     = 4,
   parameter int U_W      = 8,
   parameter bit IREF_REG = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  smp_vld,
   input  logic [V_W-1:0]        vout_code,
   input  logic [V_W-1:0]        vref_code,
   input  logic [V_W-1:0]        vline_code,
   input  logic [V_W-1:0]        step_width,
   input  logic [C_W-1:0]        k_gain,
   input  logic [C_W-1:0]        a_coef,
   output logic [U_W-1:0]        ctl_word,
   output logic signed [E_W-1:0] err_bin,
   output logic [U_W-1:0]        iref
);
   generate
      if (E_W < 2 || E_W > 16) begin : g_bad_ew
         $error("E_W out of range");
      end
      if (FRAC < 0 || FRAC >= C_W) begin : g_bad_frac
         $error("FRAC must be below C_W");
      end
      if (U_W < 2 || V_W < 2) begin : g_bad_w
         $error("data widths too small");
      end
   endgenerate

   logic signed [E_W-1:0] err_now;
   logic [U_W-1:0]        u_next;

   dzr_bin_quant #(.V_W(V_W), .E_W(E_W)) u_quant (
      .vout_code (vout_code),
      .vref_code (vref_code),
      .step_width(step_width),
      .err       (err_now)
   );

   dzr_pi_core #(.E_W(E_W), .C_W(C_W), .FRAC(FRAC), .U_W(U_W)) u_pi (
      .clk    (clk),
      .rst    (rst),
      .smp_vld(smp_vld),
      .err_in (err_now),
      .k_gain (k_gain),
      .a_coef (a_coef),
      .u_q    (ctl_word),
      .u_nxt  (u_next),
      .err_q  (err_bin)
   );

   dzr_iref_mult #(.U_W(U_W), .V_W(V_W), .IREF_REG(IREF_REG)) u_mult (
      .clk       (clk),
      .rst       (rst),
      .smp_vld   (smp_vld),
      .u_nxt     (u_next),
      .u_q       (ctl_word),
      .vline_code(vline_code),
      .iref      (iref)
   );

endmodule

// File: tb/tb_dz_volt_reg.sv
module tb_dz_volt_reg;
   localparam int CLK_P = 10;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic smp_vld = 1'b0;
   logic [7:0] vout_code = 8'd0, vref_code = 8'd0, vline_code = 8'd0;
   logic [7:0] step_width = 8'd8, k_gain = 8'd0, a_coef = 8'd0;
   logic [7:0] ctl_word;
   logic signed [5:0] err_bin;
   logic [7:0] iref;

   int n_chk = 0;
   int n_err = 0;
   int m_u = 0;
   int m_ep = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   dz_volt_reg dut (
      .clk(clk), .rst(rst), .smp_vld(smp_vld),
      .vout_code(vout_code), .vref_code(vref_code), .vline_code(vline_code),
      .step_width(step_width), .k_gain(k_gain), .a_coef(a_coef),
      .ctl_word(ctl_word), .err_bin(err_bin), .iref(iref)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int ref_err(input int vo, input int vr, input int bw);
      int d, mg, q, ix;
      d  = vr - vo;
      mg = (d < 0) ? -d : d;
      q  = (bw == 0) ? 1 : bw;
      ix = (2 * mg + q) / (2 * q);
      if (ix > 31) ix = 31;
      return (d < 0) ? -ix : ix;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; smp_vld = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      m_u = 0; m_ep = 0;
   endtask

   // one valid sample; checks all three outputs one edge later
   task automatic sample(input int vo, input int vr, input int vl, input string req);
      int e, t, dl, un;
      @(negedge clk);
      vout_code = 8'(vo); vref_code = 8'(vr); vline_code = 8'(vl);
      smp_vld = 1'b1;
      e  = ref_err(vo, vr, int'(step_width));
      t  = 16 * e - int'(a_coef) * m_ep;
      dl = (t * int'(k_gain)) / 256;
      un = m_u + dl;
      if (un < 0) un = 0;
      if (un > 255) un = 255;
      m_u = un; m_ep = e;
      @(negedge clk);
      smp_vld = 1'b0;
      chk({req, " err_bin"}, int'(err_bin), e);
      chk({req, " ctl_word"}, int'(ctl_word), un);
      chk({req, " iref"}, int'(iref), (un * vl) >> 8);
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 ctl_word", int'(ctl_word), 0);
      chk("R1 err_bin", int'(err_bin), 0);
      chk("R1 iref", int'(iref), 0);
   endtask

   task automatic t_ripple();
      do_reset();
      step_width = 8'd8; k_gain = 8'd16; a_coef = 8'd8;
      for (int v = 125; v <= 131; v++) begin
         sample(v, 128, 100, "R2");
         chk("R2 zero bin", int'(err_bin), 0);
      end
      chk("R2 u still", int'(ctl_word), 0);
   endtask

   task automatic t_bins();
      do_reset();
      step_width = 8'd8; k_gain = 8'd0; a_coef = 8'd0;
      sample(124, 128, 50, "R3"); chk("R3 d=4", int'(err_bin), 1);
      sample(117, 128, 50, "R3"); chk("R3 d=11", int'(err_bin), 1);
      sample(116, 128, 50, "R3"); chk("R3 d=12", int'(err_bin), 2);
      sample(140, 128, 50, "R3"); chk("R3 d=-12", int'(err_bin), -2);
      sample(132, 128, 50, "R3"); chk("R3 d=-4", int'(err_bin), -1);
   endtask

   task automatic t_errsat();
      do_reset();
      k_gain = 8'd0; a_coef = 8'd0; step_width = 8'd1;
      sample(50, 200, 0, "R4"); chk("R4 pos sat", int'(err_bin), 31);
      sample(255, 0, 0, "R4"); chk("R4 neg sat", int'(err_bin), -31);
      step_width = 8'd0;
      sample(10, 13, 0, "R4"); chk("R4 zero width", int'(err_bin), 3);
      step_width = 8'd8;
   endtask

   task automatic t_round();
      do_reset();
      step_width = 8'd8; k_gain = 8'd16; a_coef = 8'd0;
      sample(120, 128, 10, "R5"); chk("R5 step up", int'(ctl_word), 1);
      k_gain = 8'd3;
      sample(136, 128, 10, "R6"); chk("R6 toward zero", int'(ctl_word), 1);
   endtask

   task automatic t_clamp();
      do_reset();
      step_width = 8'd1; k_gain = 8'd255; a_coef = 8'd0;
      sample(0, 255, 0, "R7"); chk("R7 top", int'(ctl_word), 255);
      sample(0, 255, 0, "R7"); chk("R7 top again", int'(ctl_word), 255);
      sample(255, 0, 0, "R7"); chk("R7 bottom", int'(ctl_word), 0);
      step_width = 8'd8;
   endtask

   task automatic t_prev();
      do_reset();
      step_width = 8'd8; k_gain = 8'd16; a_coef = 8'd16;
      sample(112, 128, 0, "R8"); chk("R8 first", int'(ctl_word), 2);
      chk("R8 stored bin", int'(err_bin), 2);
      sample(128, 128, 0, "R8"); chk("R8 uses e_prev", int'(ctl_word), 0);
      chk("R8 stored bin zero", int'(err_bin), 0);
   endtask

   task automatic t_iref();
      do_reset();
      step_width = 8'd1; k_gain = 8'd255; a_coef = 8'd0;
      sample(0, 255, 200, "R9"); chk("R9 product", int'(iref), 199);
      sample(0, 255, 255, "R9"); chk("R9 full", int'(iref), 254);
      step_width = 8'd8;
   endtask

   task automatic t_idle();
      int u0, e0, i0;
      do_reset();
      step_width = 8'd8; k_gain = 8'd40; a_coef = 8'd4;
      sample(100, 128, 180, "R10");
      u0 = int'(ctl_word); e0 = int'(err_bin); i0 = int'(iref);
      for (int c = 0; c < 5; c++) begin
         @(negedge clk);
         vout_code = 8'(c * 40); vref_code = 8'(255 - c); vline_code = 8'(c * 30);
      end
      @(negedge clk);
      chk("R10 ctl_word", int'(ctl_word), u0);
      chk("R10 err_bin", int'(err_bin), e0);
      chk("R10 iref", int'(iref), i0);
   endtask

   task automatic t_latency();
      do_reset();
      step_width = 8'd4; k_gain = 8'd32; a_coef = 8'd0;
      @(negedge clk);
      vout_code = 8'd100; vref_code = 8'd120; vline_code = 8'd128;
      smp_vld = 1'b1;
      #(CLK_P/2 - 2);
      chk("R11 before edge", int'(ctl_word), 0);
      @(negedge clk);
      smp_vld = 1'b0;
      // e = 5, delta = 32*80/256 = 10
      chk("R11 after edge err", int'(err_bin), 5);
      chk("R11 after edge u", int'(ctl_word), 10);
      chk("R11 after edge iref", int'(iref), 5);
      m_u = 10; m_ep = 5;
   endtask

   task automatic t_mixed();
      int lf;
      do_reset();
      step_width = 8'd6; k_gain = 8'd24; a_coef = 8'd12;
      lf = 8'h5a;
      for (int s = 0; s < 30; s++) begin
         lf = ((lf << 1) ^ (((lf >> 7) ^ (lf >> 5) ^ (lf >> 4) ^ (lf >> 3)) & 1)) & 8'hff;
         sample(lf, 128, (lf * 3) & 8'hff, "R5 mixed");
      end
   endtask

   initial begin
      t_reset();
      t_ripple();
      t_bins();
      t_errsat();
      t_round();
      t_clamp();
      t_prev();
      t_iref();
      t_idle();
      t_latency();
      t_mixed();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule